// File: doc/BRIEF.md
# Round-Robin Voice Interrupt Arbiter

This block gathers two kinds of interrupt pending flags, one for wave-position events and one for volume-ramp events, from a bank of up to 32 synthesis voices. It summarises them into two bits of a global status byte and raises an interrupt request line. Service software then reads a voice status byte, one voice at a time. Each read names one pending voice, reports which of its two sources are pending, and acknowledges both of them.

A programmable active-voice count limits which voices take part. Voices at or above the count keep their pending flags, but they neither raise the interrupt nor get reported until the count grows to cover them. The reported voice is chosen round-robin. A pointer moves forward from its last position to the next pending voice and wraps to zero at the active count. The status bits owned by other interrupt sources (timers, DMA) pass through the block unchanged.

Top module: `voice_irq_arbiter`

## Requirements
- R1: While rst_ni is low, and after it is released, every pending flag is clear and the pointer is 0. The active count is 14, voice_stat_o reads 8'hE0, global status bits 6 and 5 are 0, and irq_o is low when ext_status_i is 0.
- R2: A write on cnt_we_i sets the active count to cnt_data_i + 1, clamped to the range 14..32. Any value of 13 or less becomes 14, and 32 or more becomes 32.
- R3: Only voices whose index is below the active count affect status, pointer and irq_o. Flags set on other voices are kept and take effect once the count covers them.
- R4: One cycle after the pending flags change, glob_status_o bit 6 shows whether any counted voice has a ramp flag and bit 5 whether any counted voice has a wave flag. The other six bits of glob_status_o equal ext_status_i.
- R5: One cycle after the flags change, if any counted voice is pending, the pointer moves to the lowest pending counted voice at or above its current value. If there is none, it moves to the lowest pending counted voice overall, which also covers a pointer at or above the count. With nothing pending, the pointer holds.
- R6: voice_stat_o = {no_wave, no_ramp, 1, ptr[4:0]}. Bit 7 is 1 when the pointed voice has no wave flag, bit 6 is 1 when it has no ramp flag, and bit 5 is always 1. The flags are read regardless of the count.
- R7: A pulse on stat_rd_i clears both flags of the pointed voice at the next edge. A set strobe for that voice in the same cycle wins and leaves its flag set.
- R8: irq_o is high exactly when irq_en_i is high and glob_status_o is nonzero.
- R9: A wave_set_i or ramp_set_i bit sets the flag of that source for that voice at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wave_set_i | input | 32 | Per-voice wave interrupt set strobes |
| ramp_set_i | input | 32 | Per-voice ramp interrupt set strobes |
| cnt_we_i | input | 1 | Active-voice count write strobe |
| cnt_data_i | input | 6 | Active-voice count field (count minus one) |
| stat_rd_i | input | 1 | Voice status read strobe, acknowledges the pointed voice |
| irq_en_i | input | 1 | Global interrupt enable |
| ext_status_i | input | 8 | Status bits of other sources; bits 6 and 5 are replaced |
| glob_status_o | output | 8 | Global interrupt status byte |
| voice_stat_o | output | 8 | Encoded status of the pointed voice |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check four things on every cycle. After a rescan with a counted voice pending, the pointer lies below the active count and names a voice that was pending. With no counted voice pending, both summary bits drop. An acknowledge with no competing set strobe leaves the reported voice clear. The bench scenarios cover the rest: the exact choice among several pending voices after wrap-around, the clamping of the count at both ends, the flags kept above the count and revealed when the count grows, and the set-wins rule on a simultaneous read.

// File: rtl/vir_pkg.sv
package vir_pkg;
  localparam int unsigned STAT_WAVE_BIT = 5;
  localparam int unsigned STAT_RAMP_BIT = 6;

  typedef struct packed {
    logic       no_wave;
    logic       no_ramp;
    logic       tag;
    logic [4:0] voice;
  } vstat_t;
endpackage

// File: rtl/vir_cnt_dec.sv
module vir_cnt_dec #(
  parameter int unsigned NUM_VOICES = 32,
  parameter int unsigned MIN_ACTIVE = 14,
  parameter int unsigned FIELD_W    = 6,
  localparam int unsigned CNT_W     = $clog2(NUM_VOICES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [FIELD_W-1:0]    data_i,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [NUM_VOICES-1:0] mask_o
);
  localparam int unsigned RAW_W = FIELD_W + 1;

  logic [RAW_W-1:0] raw;
  logic [CNT_W-1:0] clamped, cnt_q;

  assign raw = {1'b0, data_i} + RAW_W'(1);

  always_comb begin
    if (raw < RAW_W'(MIN_ACTIVE))      clamped = CNT_W'(MIN_ACTIVE);
    else if (raw > RAW_W'(NUM_VOICES)) clamped = CNT_W'(NUM_VOICES);
    else                               clamped = CNT_W'(raw);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= CNT_W'(MIN_ACTIVE);
    else if (we_i) cnt_q <= clamped;
  end

  for (genvar i = 0; i < NUM_VOICES; i++) begin : g_mask
    assign mask_o[i] = cnt_q > CNT_W'(i);
  end

  assign cnt_o = cnt_q;

  // R2: count never leaves the legal range
  a_r2_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q >= CNT_W'(MIN_ACTIVE)) && (cnt_q <= CNT_W'(NUM_VOICES)));
endmodule

// File: rtl/vir_pend_bank.sv
module vir_pend_bank #(
  parameter int unsigned NUM_VOICES = 32,
  localparam int unsigned VW        = $clog2(NUM_VOICES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_VOICES-1:0] set_i,
  input  logic                  clr_i,
  input  logic [VW-1:0]         clr_idx_i,
  output logic [NUM_VOICES-1:0] pend_o
);
  for (genvar i = 0; i < NUM_VOICES; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               q <= 1'b0;
      else if (set_i[i])                         q <= 1'b1;
      else if (clr_i && clr_idx_i == VW'(i))     q <= 1'b0;
    end
    assign pend_o[i] = q;
  end

  // R7: an acknowledge without a competing set leaves the voice clear
  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && ((set_i >> clr_idx_i) & NUM_VOICES'(1)) == '0)
      |=> ((pend_o >> $past(clr_idx_i)) & NUM_VOICES'(1)) == '0);
endmodule

// File: rtl/vir_rr_pick.sv
module vir_rr_pick #(
  parameter int unsigned NUM_VOICES = 32,
  localparam int unsigned VW        = $clog2(NUM_VOICES)
) (
  input  logic [NUM_VOICES-1:0] req_i,
  input  logic [VW-1:0]         start_i,
  output logic                  found_o,
  output logic [VW-1:0]         idx_o
);
  logic [NUM_VOICES-1:0] above, hi;
  logic [VW-1:0]         hi_idx, lo_idx;

  for (genvar i = 0; i < NUM_VOICES; i++) begin : g_above
    assign above[i] = VW'(i) >= start_i;
  end
  assign hi = req_i & above;

  always_comb begin
    hi_idx = '0;
    lo_idx = '0;
    for (int i = NUM_VOICES - 1; i >= 0; i--) begin
      if (hi[i])    hi_idx = VW'(i);
      if (req_i[i]) lo_idx = VW'(i);
    end
  end

  assign found_o = |req_i;
  assign idx_o   = (|hi) ? hi_idx : lo_idx;
endmodule

// File: rtl/voice_irq_arbiter.sv
module voice_irq_arbiter
  import vir_pkg::*;
#(
  parameter int unsigned NUM_VOICES = 32,
  parameter int unsigned MIN_ACTIVE = 14,
  parameter int unsigned FIELD_W    = 6,
  localparam int unsigned VW        = $clog2(NUM_VOICES),
  localparam int unsigned CNT_W     = $clog2(NUM_VOICES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_VOICES-1:0] wave_set_i,
  input  logic [NUM_VOICES-1:0] ramp_set_i,
  input  logic                  cnt_we_i,
  input  logic [FIELD_W-1:0]    cnt_data_i,
  input  logic                  stat_rd_i,
  input  logic                  irq_en_i,
  input  logic [7:0]            ext_status_i,
  output logic [7:0]            glob_status_o,
  output logic [7:0]            voice_stat_o,
  output logic                  irq_o
);
  logic [CNT_W-1:0]      cnt;
  logic [NUM_VOICES-1:0] mask, wave_pend, ramp_pend, wave_m, ramp_m, any_m;
  logic [VW-1:0]         ptr_q, next_idx;
  logic                  found, wave_any_q, ramp_any_q;
  vstat_t                vs;

  vir_cnt_dec #(.NUM_VOICES(NUM_VOICES), .MIN_ACTIVE(MIN_ACTIVE), .FIELD_W(FIELD_W)) u_cnt (
    .clk_i, .rst_ni, .we_i(cnt_we_i), .data_i(cnt_data_i), .cnt_o(cnt), .mask_o(mask)
  );

  vir_pend_bank #(.NUM_VOICES(NUM_VOICES)) u_wave (
    .clk_i, .rst_ni, .set_i(wave_set_i), .clr_i(stat_rd_i), .clr_idx_i(ptr_q), .pend_o(wave_pend)
  );

  vir_pend_bank #(.NUM_VOICES(NUM_VOICES)) u_ramp (
    .clk_i, .rst_ni, .set_i(ramp_set_i), .clr_i(stat_rd_i), .clr_idx_i(ptr_q), .pend_o(ramp_pend)
  );

  assign wave_m = wave_pend & mask;
  assign ramp_m = ramp_pend & mask;
  assign any_m  = wave_m | ramp_m;

  vir_rr_pick #(.NUM_VOICES(NUM_VOICES)) u_pick (
    .req_i(any_m), .start_i(ptr_q), .found_o(found), .idx_o(next_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      wave_any_q <= 1'b0;
      ramp_any_q <= 1'b0;
    end else begin
      if (found) ptr_q <= next_idx;
      wave_any_q <= |wave_m;
      ramp_any_q <= |ramp_m;
    end
  end

  always_comb begin
    glob_status_o = ext_status_i;
    glob_status_o[STAT_WAVE_BIT] = wave_any_q;
    glob_status_o[STAT_RAMP_BIT] = ramp_any_q;
  end

  assign vs.no_wave   = ~wave_pend[ptr_q];
  assign vs.no_ramp   = ~ramp_pend[ptr_q];
  assign vs.tag       = 1'b1;
  assign vs.voice     = 5'(ptr_q);
  assign voice_stat_o = vs;

  assign irq_o = irq_en_i && (glob_status_o != 8'h00);

  // R5: after a rescan the pointer stays inside the counted voices
  a_r5_ptr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|any_m && !cnt_we_i) |=> (CNT_W'(ptr_q) < cnt));

  // R5: after a rescan the pointer names a voice that was pending
  a_r5_ptr_hits_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|any_m) |=> (($past(any_m) >> ptr_q) & NUM_VOICES'(1)) != '0);

  // R3: with no counted voice pending both summary bits drop
  a_r3_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_m == '0) |=> (glob_status_o[STAT_WAVE_BIT] == 1'b0) && (glob_status_o[STAT_RAMP_BIT] == 1'b0));
endmodule

// File: tb/voice_irq_arbiter_tb_top.sv
module voice_irq_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  typedef struct packed {
    logic [31:0] wave;
    logic [31:0] ramp;
    logic        we;
    logic [5:0]  cdata;
    logic        rd;
    logic [7:0]  exp_vs;
    logic [7:0]  exp_gs;
  } vec_t;

  // count starts at 14, ext_status 0, irq enabled
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0008, 32'h0,          1'b0, 6'h00, 1'b0, 8'h63, 8'h20}, // R9 wave v3
    '{32'h0,          32'h0000_0208, 1'b0, 6'h00, 1'b0, 8'h23, 8'h60}, // R4 ramp v3,v9
    '{32'h0,          32'h0,          1'b0, 6'h00, 1'b1, 8'hA9, 8'h40}, // R7 ack v3 -> v9
    '{32'h0010_0000, 32'h0,          1'b0, 6'h00, 1'b0, 8'hA9, 8'h40}, // R3 v20 uncounted
    '{32'h0,          32'h0,          1'b0, 6'h00, 1'b1, 8'hE9, 8'h00}, // R5 hold when idle
    '{32'h0,          32'h0,          1'b1, 6'h1F, 1'b0, 8'h74, 8'h20}, // R3 count 32 reveals v20
    '{32'h0000_0004, 32'h0,          1'b0, 6'h00, 1'b0, 8'h74, 8'h20}, // R5 stays on pending
    '{32'h0,          32'h0,          1'b0, 6'h00, 1'b1, 8'h62, 8'h20}, // R5 wrap to v2
    '{32'h0,          32'h8000_0000, 1'b0, 6'h00, 1'b0, 8'h62, 8'h60}, // R4 ramp v31
    '{32'h0,          32'h0,          1'b0, 6'h00, 1'b1, 8'hBF, 8'h40}, // R6 ramp only
    '{32'h0,          32'h0,          1'b1, 6'h00, 1'b0, 8'hBF, 8'h00}, // R2 clamp low 14
    '{32'h0000_0020, 32'h0,          1'b0, 6'h00, 1'b0, 8'h65, 8'h20}, // R5 ptr above count wraps
    '{32'h0,          32'h0,          1'b1, 6'h3F, 1'b0, 8'h65, 8'h60}, // R2 clamp high 32
    '{32'h0000_0020, 32'h0,          1'b0, 6'h00, 1'b1, 8'h65, 8'h60}, // R7 set wins over ack
    '{32'h0,          32'h0,          1'b1, 6'h11, 1'b0, 8'h65, 8'h20}, // R2 count 18
    '{32'h0,          32'h0,          1'b0, 6'h00, 1'b1, 8'hE5, 8'h00}, // R7 ack v5
    '{32'h0,          32'h0,          1'b1, 6'h20, 1'b0, 8'hBF, 8'h40}, // R2 33 clamps to 32
    '{32'h0,          32'h0,          1'b0, 6'h00, 1'b1, 8'hFF, 8'h00}  // R7 ack v31
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] wave_set = '0, ramp_set = '0;
  logic        cnt_we = 1'b0, stat_rd = 1'b0, irq_en = 1'b1;
  logic [5:0]  cnt_data = '0;
  logic [7:0]  ext_status = '0;
  logic [7:0]  glob_status, voice_stat;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  voice_irq_arbiter dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wave_set_i(wave_set), .ramp_set_i(ramp_set),
    .cnt_we_i(cnt_we), .cnt_data_i(cnt_data), .stat_rd_i(stat_rd), .irq_en_i(irq_en),
    .ext_status_i(ext_status), .glob_status_o(glob_status), .voice_stat_o(voice_stat), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle, idle one cycle, then sample
  task automatic step(input logic [31:0] w, input logic [31:0] r, input logic we,
                      input logic [5:0] d, input logic rd);
    @(negedge clk);
    wave_set = w; ramp_set = r; cnt_we = we; cnt_data = d; stat_rd = rd;
    @(negedge clk);
    wave_set = '0; ramp_set = '0; cnt_we = 1'b0; stat_rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 vstat in reset", voice_stat, 8'hE0);
    chk("R1 glob in reset", glob_status, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 vstat after reset", voice_stat, 8'hE0);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wave, VECS[i].ramp, VECS[i].we, VECS[i].cdata, VECS[i].rd);
      chk($sformatf("R6 vec %0d vstat", i), voice_stat, VECS[i].exp_vs);
      chk($sformatf("R4 vec %0d glob", i), glob_status, VECS[i].exp_gs);
      chk($sformatf("R8 vec %0d irq", i), {7'd0, irq}, {7'd0, VECS[i].exp_gs != 8'h00});
    end

    // mid-run reset restores everything
    step(32'h0000_0010, '0, 1'b0, '0, 1'b0);
    chk("R9 wave v4", voice_stat, 8'h64);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 vstat mid reset", voice_stat, 8'hE0);
    chk("R1 glob mid reset", glob_status, 8'h00);
    rst_ni = 1'b1;
    step(32'h0010_0000, '0, 1'b0, '0, 1'b0);
    chk("R2 count back to 14, v20 ignored", glob_status, 8'h00);
    chk("R3 v20 not reported", voice_stat, 8'hE0);
    step(32'h0000_2000, '0, 1'b0, '0, 1'b0);
    chk("R3 v13 counted", voice_stat, 8'h6D);
    chk("R4 wave summary", glob_status, 8'h20);

    // other status bits pass through, bits 6:5 replaced
    ext_status = 8'h84;
    @(negedge clk);
    chk("R4 ext pass", glob_status, 8'hA4);
    chk("R8 irq on", {7'd0, irq}, 8'h01);
    ext_status = 8'h60;
    @(negedge clk);
    chk("R4 ext bits 6:5 replaced", glob_status, 8'h20);
    irq_en = 1'b0;
    @(negedge clk);
    chk("R8 irq gated", {7'd0, irq}, 8'h00);
    ext_status = 8'h00; irq_en = 1'b1;
    step('0, '0, 1'b0, '0, 1'b1);
    chk("R7 ack v13", voice_stat, 8'hED);
    chk("R8 irq idle", {7'd0, irq}, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule